// File: doc/BRIEF.md
# Banked Stack Pointer Controller

This block holds the stack register of a processor core as three physical pointers: a user pointer, an interrupt pointer and a master pointer. Two mode bits in a 16-bit status register choose which pointer is live. The core issues one of four stack commands: subroutine call, subroutine return, exception entry or exception return. The block then pushes or pops the program counter and the status register over a 32-bit memory port that has a ready handshake, and it moves the live pointer.

Exception entry always forces supervisor mode before the first push, so the saved state lands on a supervisor stack whatever mode was running. Exception return restores the saved status register only after both pops finish. From then on, the restored mode bits choose the pointer for the code that follows. While no command is running, the core can also load the status register directly, which changes mode.

Top module: `sp_bank_ctrl`

## Requirements
- R1: After reset the status register reads 0x2000 (supervisor, interrupt pointer live), each of the three pointers holds its reset-value input, and `busy_o` and `mem_req_o` are low.
- R2: Status bit 13 is the supervisor bit and bit 12 is the master-select bit. Bit 13 clear makes the user pointer live. Bit 13 set with bit 12 clear makes the interrupt pointer live, and both bits set make the master pointer live. `sp_o` always shows the live pointer.
- R3: A call (`cmd_i`=0) writes `pc_i` to the live pointer minus 4 and leaves the live pointer decremented by 4.
- R4: A return (`cmd_i`=1) reads the word at the live pointer, presents it on `pc_o` with a one-cycle `pc_valid_o` pulse, and leaves the live pointer incremented by 4.
- R5: Exception entry (`cmd_i`=2) sets the supervisor bit and keeps the master-select bit. It then writes `pc_i` at the selected supervisor pointer minus 4, and after that the status register from before entry at minus 8. The supervisor pointer drops by 8 and the user pointer is left untouched.
- R6: Exception return (`cmd_i`=3) reads the status word at the live pointer and then the program counter at the live pointer plus 4, raising the pointer by 8. After the second read, the status register takes the low 16 bits of the first word, and those bits select the live pointer.
- R7: The whole 16-bit status register, including the five condition bits in bits 4:0, is stacked zero-extended and comes back bit for bit on exception return.
- R8: A request holds its address, direction and write data until `mem_ready_i` is high at a clock edge. A pointer changes only at the edge that completes an access.
- R9: `busy_o` rises in the cycle after a command is accepted and falls once the last access of that command completes. Commands and status loads presented while busy have no effect.
- R10: While idle with no command valid, `sr_load_i` writes `sr_i` into the status register, which is visible one cycle later. A command offered in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| usp_rst_i | input | 32 | User pointer reset value |
| isp_rst_i | input | 32 | Interrupt pointer reset value |
| msp_rst_i | input | 32 | Master pointer reset value |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | 0 call, 1 return, 2 exception entry, 3 exception return |
| pc_i | input | 32 | Program counter to save |
| sr_load_i | input | 1 | Direct status register load |
| sr_i | input | 16 | Status value to load |
| busy_o | output | 1 | Command sequence in progress |
| sp_o | output | 32 | Live stack pointer |
| sr_o | output | 16 | Status register |
| pc_o | output | 32 | Last popped program counter |
| pc_valid_o | output | 1 | One-cycle pulse when `pc_o` updates |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes at this edge |

## Verification
The checker assumes that the memory side raises `mem_ready_i` only while a request is open, and that it returns read data in the same cycle as ready. It also assumes that the core drives the command and status-load strobes for exactly one cycle. The bench's memory model asserts ready only after counting a programmable number of wait cycles on an open request. Its tasks change strobes only on falling edges and drop them after one cycle, except for the deliberate strobes during a busy window, which test that such input is ignored.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  localparam int SR_S_BIT = 13;
  localparam int SR_M_BIT = 12;

  typedef enum logic [1:0] {
    CMD_CALL = 2'd0,
    CMD_RET  = 2'd1,
    CMD_EXC  = 2'd2,
    CMD_ERET = 2'd3
  } sp_cmd_e;

  typedef enum logic [1:0] {
    SEL_USP = 2'd0,
    SEL_ISP = 2'd1,
    SEL_MSP = 2'd2
  } sp_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PC, ST_PUSH_SR, ST_POP_SR, ST_POP_PC
  } seq_st_e;

  function automatic sp_sel_e sel_from_sr(input logic [15:0] sr);
    if (!sr[SR_S_BIT])     return SEL_USP;
    else if (sr[SR_M_BIT]) return SEL_MSP;
    else                   return SEL_ISP;
  endfunction
endpackage

// File: rtl/sp_bank_regs.sv
module sp_bank_regs
  import sp_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0][DW-1:0] rst_val_i,
  input  sp_sel_e            sel_i,
  input  logic               we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      sp_o
);
  localparam int NBANK = 3;

  logic [NBANK-1:0][DW-1:0] bank;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= rst_val_i[g];
      else if (we_i && (sel_i == sp_sel_e'(g)))  q <= wdata_i;
    end
    assign bank[g] = q;
  end

  always_comb begin
    case (sel_i)
      SEL_USP: sp_o = bank[0];
      SEL_MSP: sp_o = bank[2];
      default: sp_o = bank[1];
    endcase
  end
endmodule

// File: rtl/sp_bank_fsm.sv
module sp_bank_fsm
  import sp_bank_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  sp_cmd_e        cmd_i,
  input  logic [DW-1:0]  pc_i,
  input  logic           sr_load_i,
  input  logic [SRW-1:0] sr_i,
  input  logic [DW-1:0]  sp_i,
  output logic           busy_o,
  output logic [SRW-1:0] sr_o,
  output logic [DW-1:0]  pc_o,
  output logic           pc_valid_o,
  output logic           sp_we_o,
  output logic [DW-1:0]  sp_wdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i
);
  localparam logic [DW-1:0]  STEP     = DW'(DW / 8);
  localparam logic [SRW-1:0] SR_RESET = SRW'(1) << SR_S_BIT;

  seq_st_e        state_q, state_d;
  logic [SRW-1:0] sr_q, sr_save_q, sr_pend_q;
  logic [DW-1:0]  pc_save_q, pc_q;
  logic           exc_q, pcv_q;
  logic           idle, accept, done;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && cmd_valid_i;
  assign done   = mem_req_o && mem_ready_i;

  assign busy_o      = !idle;
  assign mem_req_o   = !idle;
  assign mem_we_o    = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_SR);
  assign mem_addr_o  = mem_we_o ? sp_i - STEP : sp_i;
  assign mem_wdata_o = (state_q == ST_PUSH_SR) ? {{(DW-SRW){1'b0}}, sr_save_q} : pc_save_q;
  assign sp_we_o     = done;
  assign sp_wdata_o  = mem_we_o ? sp_i - STEP : sp_i + STEP;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) begin
        unique case (cmd_i)
          CMD_CALL, CMD_EXC: state_d = ST_PUSH_PC;
          CMD_RET:           state_d = ST_POP_PC;
          CMD_ERET:          state_d = ST_POP_SR;
          default:           state_d = ST_IDLE;
        endcase
      end
      ST_PUSH_PC: if (done) state_d = exc_q ? ST_PUSH_SR : ST_IDLE;
      ST_PUSH_SR: if (done) state_d = ST_IDLE;
      ST_POP_SR:  if (done) state_d = ST_POP_PC;
      ST_POP_PC:  if (done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sr_q      <= SR_RESET;
      sr_save_q <= '0;
      sr_pend_q <= '0;
      pc_save_q <= '0;
      pc_q      <= '0;
      exc_q     <= 1'b0;
      pcv_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      pcv_q   <= 1'b0;
      if (accept) begin
        pc_save_q <= pc_i;
        exc_q     <= (cmd_i == CMD_EXC) || (cmd_i == CMD_ERET);
        if (cmd_i == CMD_EXC) begin
          sr_save_q         <= sr_q;
          sr_q[SR_S_BIT]    <= 1'b1;  // supervisor before first push
        end
      end else if (idle && sr_load_i) begin
        sr_q <= sr_i;
      end
      if (done && state_q == ST_POP_SR) sr_pend_q <= mem_rdata_i[SRW-1:0];
      if (done && state_q == ST_POP_PC) begin
        pc_q  <= mem_rdata_i;
        pcv_q <= 1'b1;
        if (exc_q) sr_q <= sr_pend_q;  // restored mode takes over after last pop
      end
    end
  end

  assign sr_o       = sr_q;
  assign pc_o       = pc_q;
  assign pc_valid_o = pcv_q;
endmodule

// File: rtl/sp_bank_ctrl.sv
module sp_bank_ctrl
  import sp_bank_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  usp_rst_i,
  input  logic [DW-1:0]  isp_rst_i,
  input  logic [DW-1:0]  msp_rst_i,
  input  logic           cmd_valid_i,
  input  logic [1:0]     cmd_i,
  input  logic [DW-1:0]  pc_i,
  input  logic           sr_load_i,
  input  logic [SRW-1:0] sr_i,
  output logic           busy_o,
  output logic [DW-1:0]  sp_o,
  output logic [SRW-1:0] sr_o,
  output logic [DW-1:0]  pc_o,
  output logic           pc_valid_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i
);
  logic          sp_we;
  logic [DW-1:0] sp_wdata;
  sp_sel_e       sel;

  assign sel = sel_from_sr(16'(sr_o));

  sp_bank_regs #(.DW(DW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i ({msp_rst_i, isp_rst_i, usp_rst_i}),
    .sel_i     (sel),
    .we_i      (sp_we),
    .wdata_i   (sp_wdata),
    .sp_o      (sp_o)
  );

  sp_bank_fsm #(.DW(DW), .SRW(SRW)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (sp_cmd_e'(cmd_i)),
    .pc_i        (pc_i),
    .sr_load_i   (sr_load_i),
    .sr_i        (sr_i),
    .sp_i        (sp_o),
    .busy_o      (busy_o),
    .sr_o        (sr_o),
    .pc_o        (pc_o),
    .pc_valid_o  (pc_valid_o),
    .sp_we_o     (sp_we),
    .sp_wdata_o  (sp_wdata),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i)
  );
endmodule

// File: rtl/sp_bank_chk.sv
module sp_bank_chk #(
  parameter int DW  = 32,
  parameter int SRW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_valid_i,
  input logic [1:0]     cmd_i,
  input logic           busy_o,
  input logic [DW-1:0]  sp_o,
  input logic [SRW-1:0] sr_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [DW-1:0]  mem_addr_o,
  input logic [DW-1:0]  mem_wdata_o,
  input logic           mem_ready_i
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  p_push_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_addr_o == sp_o - STEP);

  p_push_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ready_i |=> sp_o == $past(sp_o) - STEP);

  p_pop_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o == sp_o);

  p_exc_super_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o && cmd_i == 2'd2 |=> sr_o[13] && busy_o);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_sp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_ready_i |=> $stable(sp_o));

  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  p_busy_sr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_ready_i |=> $stable(sr_o));
endmodule

bind sp_bank_ctrl sp_bank_chk #(.DW(DW), .SRW(SRW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .busy_o      (busy_o),
  .sp_o        (sp_o),
  .sr_o        (sr_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/test_sp_bank_ctrl.sv
`timescale 1ns/1ps
module test_sp_bank_ctrl;
  localparam logic [31:0] USP0 = 32'h0000_1000;
  localparam logic [31:0] ISP0 = 32'h0000_2000;
  localparam logic [31:0] MSP0 = 32'h0000_3000;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, sr_load = 0, mem_ready = 0;
  logic [1:0]  cmd = 0;
  logic [31:0] pc = 0, mem_rdata = 0;
  logic [15:0] sr_in = 0;
  logic        busy, pc_valid, mem_req, mem_we;
  logic [31:0] sp, pc_out, mem_addr, mem_wdata;
  logic [15:0] sr;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, wr_count = 0, pcv_count = 0;
  logic [31:0] wr_addr_log [4];
  logic [31:0] mem [logic [31:0]];

  always #2 clk = ~clk;

  sp_bank_ctrl i_sp_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .usp_rst_i(USP0), .isp_rst_i(ISP0), .msp_rst_i(MSP0),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .pc_i(pc),
    .sr_load_i(sr_load), .sr_i(sr_in),
    .busy_o(busy), .sp_o(sp), .sr_o(sr), .pc_o(pc_out), .pc_valid_o(pc_valid),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  // memory model: ready after lat wait cycles, data with ready
  always @(negedge clk) begin
    if (pc_valid) pcv_count++;
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1;
        wcnt = 0;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_addr_log[wr_count % 4] = mem_addr;
          wr_count++;
        end else begin
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
      end else begin
        mem_ready = 0;
        wcnt++;
      end
    end else begin
      mem_ready = 0;
      wcnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic load_sr(input logic [15:0] v);
    sr_load = 1; sr_in = v;
    @(negedge clk);
    sr_load = 0;
  endtask

  task automatic issue(input logic [1:0] c, input logic [31:0] p);
    cmd_valid = 1; cmd = c; pc = p;
    @(negedge clk);
    cmd_valid = 0;
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 sr", 32'(sr), 32'h2000);
    chk("R1 sp", sp, ISP0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(mem_req), 0);
  endtask

  task automatic t_select();
    load_sr(16'h0000); chk("R2/R10 user sel", sp, USP0);
    chk("R10 sr loaded", 32'(sr), 32'h0000);
    load_sr(16'h3000); chk("R2 master sel", sp, MSP0);
    load_sr(16'h2000); chk("R2 isp sel", sp, ISP0);
    load_sr(16'h1000); chk("R2 user with M set", sp, USP0);
  endtask

  task automatic t_call_ret();
    int pv;
    load_sr(16'h0000);
    issue(2'd0, 32'hAAAA_0010);
    chk("R3 pushed pc", rd(USP0 - 4), 32'hAAAA_0010);
    chk("R3 sp dec", sp, USP0 - 4);
    pv = pcv_count;
    issue(2'd1, 32'h0);
    @(negedge clk);
    chk("R4 pc_o", pc_out, 32'hAAAA_0010);
    chk("R4 sp inc", sp, USP0);
    chk("R4 pc_valid once", 32'(pcv_count - pv), 1);
  endtask

  task automatic t_exc_user();
    int w0;
    load_sr(16'h001F);
    w0 = wr_count;
    issue(2'd2, 32'h1234_5678);
    chk("R5 sr super", 32'(sr), 32'h201F);
    chk("R5 isp dec 8", sp, ISP0 - 8);
    chk("R5 pc first", wr_addr_log[w0 % 4], ISP0 - 4);
    chk("R5 sr second", wr_addr_log[(w0 + 1) % 4], ISP0 - 8);
    chk("R5 pc value", rd(ISP0 - 4), 32'h1234_5678);
    chk("R7 sr stacked", rd(ISP0 - 8), 32'h0000_001F);
    issue(2'd3, 32'h0);
    @(negedge clk);
    chk("R6/R7 sr restored", 32'(sr), 32'h001F);
    chk("R6 user pointer live", sp, USP0);
    chk("R6 pc popped", pc_out, 32'h1234_5678);
    load_sr(16'h2000);
    chk("R6 isp back", sp, ISP0);
  endtask

  task automatic t_exc_master();
    load_sr(16'h3004);
    issue(2'd2, 32'h0000_0055);
    chk("R5 master dec", sp, MSP0 - 8);
    chk("R5 master sr", rd(MSP0 - 8), 32'h3004);
    chk("R5 master pc", rd(MSP0 - 4), 32'h55);
    load_sr(16'h2000); chk("R5 isp untouched", sp, ISP0);
    load_sr(16'h0000); chk("R5 usp untouched", sp, USP0);
    load_sr(16'h3000);
    issue(2'd3, 32'h0);
    @(negedge clk);
    chk("R6 master restored sr", 32'(sr), 32'h3004);
    chk("R6 master sp", sp, MSP0);
  endtask

  task automatic t_wait_busy();
    int w0;
    load_sr(16'h0000);
    lat = 3;
    w0 = wr_count;
    cmd_valid = 1; cmd = 2'd0; pc = 32'h0000_0077;
    @(negedge clk);
    cmd_valid = 0;
    @(negedge clk);
    chk("R9 busy", 32'(busy), 1);
    chk("R8 req held", 32'(mem_req), 1);
    chk("R8 addr", mem_addr, USP0 - 4);
    chk("R8 sp unchanged", sp, USP0);
    cmd_valid = 1; cmd = 2'd1; sr_load = 1; sr_in = 16'h2000;
    @(negedge clk);
    cmd_valid = 0; sr_load = 0;
    wait_idle();
    chk("R9 single push", 32'(wr_count - w0), 1);
    chk("R9 sr load ignored", 32'(sr), 32'h0000);
    chk("R8 sp after ready", sp, USP0 - 4);
    issue(2'd1, 32'h0);
    @(negedge clk);
    chk("R4 pop with waits", pc_out, 32'h77);
    chk("R4 sp restored", sp, USP0);
    lat = 0;
  endtask

  task automatic t_priority();
    load_sr(16'h0000);
    cmd_valid = 1; cmd = 2'd0; pc = 32'h99; sr_load = 1; sr_in = 16'h2000;
    @(negedge clk);
    cmd_valid = 0; sr_load = 0;
    wait_idle();
    chk("R10 cmd wins sr", 32'(sr), 32'h0000);
    chk("R10 cmd ran", sp, USP0 - 4);
    issue(2'd1, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_call_ret();
    t_exc_user();
    t_exc_master();
    t_wait_busy();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule